// File: doc/BRIEF.md
# Latency-Delayed Fetch Instruction Buffer

This block sits between an instruction fetch stage and the back end of a processor core. Fetch pushes one instruction token per cycle. Each token carries a sequence number, a destination-register count and three flags: serialize-before, privileged register access and fault. A token first enters a staging queue. It moves to an output queue only after a fixed number of cycles, set by the `LAT` parameter. Release is not decided by occupancy. It is decided by a per-cycle history of push counts: the staging head moves across exactly when a push was recorded `LAT` cycles earlier.

The back end takes tokens from the head of the output queue. A token that must serialize is held back until the reorder buffer reports empty. The block keeps a free rename-register counter. An accepted push charges the token's destination count to that counter, and a discarded token gives its count back. A squash carrying sequence number S discards every buffered token younger than S from both queues, and it trims the push history so that no discarded token is ever released. A flush discards everything and puts the block back into its idle state.

Top module: `fetch_delay_buf`

## Requirements
- R1: After reset: both queues are empty, `buf_count_o` is 0, `pop_valid_o` is 0, `idle_o` is 1, `free_regs_o` equals `NUM_PHYS`, `rename_blk_o` is 0 and `push_ready_o` is 1.
- R2: A token accepted at clock edge t reaches the head of the pop port after edge t+LAT and no earlier, provided no squash or flush cycle falls in between. Tokens leave in the order they were accepted, and the pop port shows each token's sequence number, destination count, fault flag and privileged flag unchanged.
- R3: Tokens move from staging to output at a rate of one for each push recorded LAT cycles earlier. The number of pushes still pending in the history always equals the staging occupancy.
- R4: An accepted push lowers `free_regs_o` by the token's destination count, and popping a token does not raise it. `rename_blk_o` is 1 whenever `free_regs_o` is zero or negative, and `push_ready_o` is 0 during that time.
- R5: `push_ready_o` is 0 whenever `buf_count_o` equals `MAX_BUF`, and a push offered in that state is ignored.
- R6: A squash with sequence number S removes every token whose sequence number is greater than S from both queues, and adds their destination counts back to `free_regs_o`. Sequence numbers must be pushed in strictly increasing order. The history does not advance in the squash cycle, so a surviving staged token is released one cycle later than it would have been. A removed token never appears at the pop port.
- R7: In a squash or flush cycle, `push_ready_o` and `pop_valid_o` are both 0. No push is accepted, no token is popped and no token is transferred.
- R8: When the output head has the serialize-before flag or the privileged flag set, `pop_valid_o` stays 0 while `rob_empty_i` is 0, and `pop_en_i` has no effect. Once `rob_empty_i` is 1 the token is delivered. A head with neither flag is delivered whatever the value of `rob_empty_i`.
- R9: A flush discards every buffered token, returns their destination counts to `free_regs_o`, sets `buf_count_o` to 0 and `idle_o` to 1, and clears the push history so that nothing is released afterwards.
- R10: `pop_valid_o` is 0 while the output queue is empty, and `pop_en_i` then leaves `buf_count_o` unchanged.
- R11: `buf_count_o` rises by one for each accepted push and falls by one for each pop and for each token a squash removes.
- R12: `idle_o` falls to 0 after the first accepted push that follows reset or a flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| push_valid_i | input | 1 | Fetch offers a token |
| push_seq_i | input | SEQ_W | Sequence number of the offered token |
| push_ndst_i | input | DST_W | Destination-register count of the offered token |
| push_ser_i | input | 1 | Token must wait for an empty reorder buffer |
| push_ipr_i | input | 1 | Token is a privileged register access |
| push_fault_i | input | 1 | Token carries a fault |
| push_ready_o | output | 1 | The offered token is accepted this cycle |
| pop_en_i | input | 1 | Back end takes the head token |
| rob_empty_i | input | 1 | Reorder buffer is empty |
| pop_valid_o | output | 1 | Head token may be taken this cycle |
| pop_seq_o | output | SEQ_W | Head sequence number |
| pop_ndst_o | output | DST_W | Head destination-register count |
| pop_ipr_o | output | 1 | Head privileged-access flag |
| pop_fault_o | output | 1 | Head fault flag |
| squash_i | input | 1 | Discard tokens younger than `squash_seq_i` |
| squash_seq_i | input | SEQ_W | Youngest sequence number to keep |
| flush_i | input | 1 | Discard everything and return to idle |
| buf_count_o | output | CNT_W | Tokens held in both queues |
| free_regs_o | output | FREE_W | Free rename registers, signed |
| rename_blk_o | output | 1 | Free-register counter is zero or below |
| idle_o | output | 1 | No push accepted since reset or the last flush |

## Verification
The bench builds the block with LAT=3, a staging depth of 4, an output depth of 8, MAX_BUF=6 and only 10 physical registers. The short latency keeps a few tokens in staging while others already sit in the output queue, so a single squash cuts into both queues and trims the history. The small register pool lets a single push with a large destination count drive the counter negative, which brings the rename block into reach. The small buffer cap is reached after six pushes, and the test then squashes and pops in the same cycle to confirm the squash wins. Serializing and privileged heads are held against a busy reorder buffer, and a flush is issued while tokens are split across the two queues.

// File: rtl/ifb_pkg.sv
package ifb_pkg;

   // Mode of the buffer as seen by fetch.
   typedef enum logic {
      FE_ACTIVE = 1'b0,
      FE_IDLE   = 1'b1
   } fe_mode_e;

   // Token layout: {fault, ipr, ser, ndst, seq}; seq sits at bit 0 so that
   // the queues can compare it without knowing the flag positions.
   function automatic int tok_width(input int seq_w, input int dst_w);
      return seq_w + dst_w + 3;
   endfunction

endpackage

// File: rtl/ifb_queue.sv
module ifb_queue #(
   parameter  int DEPTH = 8,
   parameter  int SEQ_W = 16,
   parameter  int DST_W = 3,
   parameter  int W     = 22,
   localparam int CW    = $clog2(DEPTH + 1),
   localparam int SW    = CW + DST_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic [W-1:0]     push_data_i,
   input  logic             pop_i,
   input  logic             kill_i,
   input  logic             kill_all_i,
   input  logic [SEQ_W-1:0] kill_seq_i,
   output logic [W-1:0]     head_o,
   output logic [CW-1:0]    count_o,
   output logic [CW-1:0]    kill_cnt_o,
   output logic [SW-1:0]    kill_dst_o
);
   localparam int AW = $clog2(DEPTH);

   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("ifb_queue: DEPTH must be a power of two, at least 2");
   end

   logic [W-1:0]     mem_q [DEPTH];
   logic [AW-1:0]    head_q;
   logic [AW-1:0]    tail;
   logic [CW-1:0]    cnt_q;
   logic [DEPTH-1:0] doomed;

   assign tail    = head_q + AW'(cnt_q);
   assign head_o  = mem_q[head_q];
   assign count_o = cnt_q;

   // A slot is doomed when it is occupied and younger than the kill point.
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic [AW-1:0] off;
      logic          live;
      assign off       = AW'(g) - head_q;
      assign live      = {1'b0, off} < cnt_q;
      assign doomed[g] = live & (kill_all_i | (mem_q[g][SEQ_W-1:0] > kill_seq_i));
   end

   always_comb begin
      kill_cnt_o = '0;
      kill_dst_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (doomed[i]) begin
            kill_cnt_o = kill_cnt_o + CW'(1);
            kill_dst_o = kill_dst_o + SW'(mem_q[i][SEQ_W +: DST_W]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         head_q <= '0;
         cnt_q  <= '0;
      end else if (kill_i) begin
         if (kill_all_i) begin
            head_q <= '0;
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q - kill_cnt_o;
         end
      end else begin
         if (pop_i) head_q <= head_q + AW'(1);
         cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
      end
   end

   always_ff @(posedge clk) begin
      if (!kill_i && push_i) mem_q[tail] <= push_data_i;
   end

   // R11: never write into a full queue, never take from an empty one
   a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill_i && push_i && !pop_i) |-> (cnt_q < CW'(DEPTH)));
   a_r10_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill_i && pop_i) |-> (cnt_q != '0));

endmodule

// File: rtl/ifb_hist.sv
module ifb_hist #(
   parameter int LAT = 4,
   parameter int DW  = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           adv_i,
   input  logic           in_i,
   input  logic           clr_all_i,
   input  logic           drop_i,
   input  logic [DW-1:0]  drop_n_i,
   output logic           release_o,
   output logic [LAT-1:0] bits_o
);
   // bit 0 holds the newest cycle, bit LAT-1 the one due for release
   logic [LAT-1:0] h_q;
   logic [LAT-1:0] h_drop;
   logic [DW-1:0]  left;

   // Clear the drop_n youngest recorded pushes.
   always_comb begin
      h_drop = h_q;
      left   = drop_n_i;
      for (int k = 0; k < LAT; k++) begin
         if (h_q[k] && left != '0) begin
            h_drop[k] = 1'b0;
            left      = left - DW'(1);
         end
      end
   end

   if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         h_q <= '0;
         else if (clr_all_i) h_q <= '0;
         else if (drop_i)    h_q <= h_drop;
         else if (adv_i)     h_q <= in_i;
      end
   end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)         h_q <= '0;
         else if (clr_all_i) h_q <= '0;
         else if (drop_i)    h_q <= h_drop;
         else if (adv_i)     h_q <= {h_q[LAT-2:0], in_i};
      end
   end

   assign release_o = h_q[LAT-1];
   assign bits_o    = h_q;

endmodule

// File: rtl/fetch_delay_buf.sv
module fetch_delay_buf #(
   parameter  int LAT         = 4,
   parameter  int STAGE_DEPTH = 8,
   parameter  int OUT_DEPTH   = 16,
   parameter  int MAX_BUF     = 12,
   parameter  int NUM_PHYS    = 64,
   parameter  int SEQ_W       = 16,
   parameter  int DST_W       = 3,
   localparam int CNT_W       = $clog2(STAGE_DEPTH + OUT_DEPTH + 1),
   localparam int FREE_W      = $clog2(NUM_PHYS + 1) + DST_W + 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     push_valid_i,
   input  logic [SEQ_W-1:0]         push_seq_i,
   input  logic [DST_W-1:0]         push_ndst_i,
   input  logic                     push_ser_i,
   input  logic                     push_ipr_i,
   input  logic                     push_fault_i,
   output logic                     push_ready_o,
   input  logic                     pop_en_i,
   input  logic                     rob_empty_i,
   output logic                     pop_valid_o,
   output logic [SEQ_W-1:0]         pop_seq_o,
   output logic [DST_W-1:0]         pop_ndst_o,
   output logic                     pop_ipr_o,
   output logic                     pop_fault_o,
   input  logic                     squash_i,
   input  logic [SEQ_W-1:0]         squash_seq_i,
   input  logic                     flush_i,
   output logic [CNT_W-1:0]         buf_count_o,
   output logic signed [FREE_W-1:0] free_regs_o,
   output logic                     rename_blk_o,
   output logic                     idle_o
);
   import ifb_pkg::*;

   localparam int TOK_W = tok_width(SEQ_W, DST_W);
   localparam int SER_B = SEQ_W + DST_W;
   localparam int IPR_B = SER_B + 1;
   localparam int FLT_B = SER_B + 2;
   localparam int SCW   = $clog2(STAGE_DEPTH + 1);
   localparam int OCW   = $clog2(OUT_DEPTH + 1);

   if (LAT < 1) begin : g_bad_lat
      $error("fetch_delay_buf: LAT must be at least 1");
   end
   if (STAGE_DEPTH < LAT) begin : g_bad_stage
      $error("fetch_delay_buf: STAGE_DEPTH must cover LAT cycles of pushes");
   end
   if (MAX_BUF < 1 || MAX_BUF > OUT_DEPTH) begin : g_bad_max
      $error("fetch_delay_buf: MAX_BUF must lie in 1..OUT_DEPTH");
   end

   logic                  kill;
   logic                  push_acc;
   logic                  xfer;
   logic                  pop_take;
   logic                  head_serial;
   logic [TOK_W-1:0]      push_tok;
   logic [TOK_W-1:0]      st_head;
   logic [TOK_W-1:0]      ou_head;
   logic [SCW-1:0]        st_cnt;
   logic [SCW-1:0]        st_kcnt;
   logic [SCW+DST_W-1:0]  st_kdst;
   logic [OCW-1:0]        ou_cnt;
   logic [OCW-1:0]        ou_kcnt;
   logic [OCW+DST_W-1:0]  ou_kdst;
   logic                  rel;
   logic [LAT-1:0]        hist_bits;
   logic signed [FREE_W-1:0] free_q;
   logic [FREE_W-1:0]     take_v;
   logic [FREE_W-1:0]     give_v;
   fe_mode_e              mode_q;

   assign kill     = squash_i | flush_i;
   assign push_tok = {push_fault_i, push_ipr_i, push_ser_i, push_ndst_i, push_seq_i};
   assign buf_count_o = CNT_W'(st_cnt) + CNT_W'(ou_cnt);

   assign push_ready_o = !kill && (buf_count_o < CNT_W'(MAX_BUF)) && (free_q > 0);
   assign push_acc     = push_valid_i && push_ready_o;
   assign xfer         = !kill && rel;

   assign head_serial = ou_head[SER_B] | ou_head[IPR_B];
   assign pop_valid_o = (ou_cnt != '0) && !kill && (!head_serial || rob_empty_i);
   assign pop_take    = pop_valid_o && pop_en_i;
   assign pop_seq_o   = ou_head[SEQ_W-1:0];
   assign pop_ndst_o  = ou_head[SEQ_W +: DST_W];
   assign pop_ipr_o   = ou_head[IPR_B];
   assign pop_fault_o = ou_head[FLT_B];

   ifb_queue #(
      .DEPTH(STAGE_DEPTH), .SEQ_W(SEQ_W), .DST_W(DST_W), .W(TOK_W)
   ) stage_q_i (
      .clk, .rst_n,
      .push_i(push_acc), .push_data_i(push_tok), .pop_i(xfer),
      .kill_i(kill), .kill_all_i(flush_i), .kill_seq_i(squash_seq_i),
      .head_o(st_head), .count_o(st_cnt), .kill_cnt_o(st_kcnt), .kill_dst_o(st_kdst)
   );

   ifb_queue #(
      .DEPTH(OUT_DEPTH), .SEQ_W(SEQ_W), .DST_W(DST_W), .W(TOK_W)
   ) out_q_i (
      .clk, .rst_n,
      .push_i(xfer), .push_data_i(st_head), .pop_i(pop_take),
      .kill_i(kill), .kill_all_i(flush_i), .kill_seq_i(squash_seq_i),
      .head_o(ou_head), .count_o(ou_cnt), .kill_cnt_o(ou_kcnt), .kill_dst_o(ou_kdst)
   );

   ifb_hist #(.LAT(LAT), .DW(SCW)) hist_i (
      .clk, .rst_n,
      .adv_i(!kill), .in_i(push_acc), .clr_all_i(flush_i),
      .drop_i(squash_i), .drop_n_i(st_kcnt),
      .release_o(rel), .bits_o(hist_bits)
   );

   assign take_v = push_acc ? FREE_W'(push_ndst_i) : '0;
   assign give_v = kill ? (FREE_W'(st_kdst) + FREE_W'(ou_kdst)) : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) free_q <= FREE_W'(NUM_PHYS);
      else        free_q <= $signed($unsigned(free_q) - take_v + give_v);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        mode_q <= FE_IDLE;
      else if (flush_i)  mode_q <= FE_IDLE;
      else if (push_acc) mode_q <= FE_ACTIVE;
   end

   assign free_regs_o  = free_q;
   assign rename_blk_o = (free_q <= 0);
   assign idle_o       = (mode_q == FE_IDLE);

   // R3: pending history pushes match the staged tokens
   a_r3_hist_tracks: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(hist_bits) == int'(st_cnt));
   // R3: a release never finds staging empty
   a_r3_release_backed: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> (st_cnt != '0));
   // R5: total occupancy never exceeds the cap
   a_r5_cap_held: assert property (@(posedge clk) disable iff (!rst_n)
      buf_count_o <= CNT_W'(MAX_BUF));
   // R6: a squash only gives registers back
   a_r6_squash_returns: assert property (@(posedge clk) disable iff (!rst_n)
      (squash_i && !flush_i) |=> (free_regs_o >= $past(free_regs_o)));
   // R7: a squash cycle never grows the buffer
   a_r7_squash_first: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i |=> (buf_count_o <= $past(buf_count_o)));
   // R8: a serializing head stays put while the reorder buffer is busy
   a_r8_serial_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (!kill && pop_en_i && ou_cnt != '0 && head_serial && !rob_empty_i)
      |=> (ou_cnt >= $past(ou_cnt)));
   // R9: a flush empties the block and returns it to idle
   a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
      flush_i |=> (buf_count_o == '0 && idle_o));

endmodule

// File: tb/fetch_delay_buf_tb_top.sv
module fetch_delay_buf_tb_top;
   localparam int LAT = 3, STG = 4, OUTD = 8, MAXB = 6, NPH = 10, SW = 8, DW = 3;
   localparam int CNT_W  = $clog2(STG + OUTD + 1);
   localparam int FREE_W = $clog2(NPH + 1) + DW + 1;

   typedef struct packed {
      logic [SW-1:0] seq;
      logic [DW-1:0] nd;
      logic          flt;
   } vec_t;
   localparam vec_t VEC [4] = '{
      '{seq: 8'd1, nd: 3'd1, flt: 1'b0},
      '{seq: 8'd2, nd: 3'd2, flt: 1'b1},
      '{seq: 8'd3, nd: 3'd0, flt: 1'b0},
      '{seq: 8'd4, nd: 3'd1, flt: 1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic push_valid, push_ser, push_ipr, push_fault;
   logic [SW-1:0] push_seq, squash_seq;
   logic [DW-1:0] push_ndst;
   logic pop_en, rob_empty, squash, flush;
   logic push_ready, pop_valid, pop_ipr, pop_fault, rename_blk, idle;
   logic [SW-1:0] pop_seq;
   logic [DW-1:0] pop_ndst;
   logic [CNT_W-1:0] buf_count;
   logic signed [FREE_W-1:0] free_regs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   fetch_delay_buf #(
      .LAT(LAT), .STAGE_DEPTH(STG), .OUT_DEPTH(OUTD), .MAX_BUF(MAXB),
      .NUM_PHYS(NPH), .SEQ_W(SW), .DST_W(DW)
   ) dut_i (
      .clk, .rst_n,
      .push_valid_i(push_valid), .push_seq_i(push_seq), .push_ndst_i(push_ndst),
      .push_ser_i(push_ser), .push_ipr_i(push_ipr), .push_fault_i(push_fault),
      .push_ready_o(push_ready),
      .pop_en_i(pop_en), .rob_empty_i(rob_empty), .pop_valid_o(pop_valid),
      .pop_seq_o(pop_seq), .pop_ndst_o(pop_ndst), .pop_ipr_o(pop_ipr),
      .pop_fault_o(pop_fault),
      .squash_i(squash), .squash_seq_i(squash_seq), .flush_i(flush),
      .buf_count_o(buf_count), .free_regs_o(free_regs),
      .rename_blk_o(rename_blk), .idle_o(idle)
   );

   task automatic chk(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", what, act, exp);
      end
   endtask

   task automatic clr();
      push_valid = 0; push_seq = '0; push_ndst = '0;
      push_ser = 0; push_ipr = 0; push_fault = 0;
      pop_en = 0; rob_empty = 1; squash = 0; squash_seq = '0; flush = 0;
   endtask

   task automatic push(input int s, input int nd, input bit ser, input bit ipr, input bit flt);
      push_valid = 1; push_seq = SW'(s); push_ndst = DW'(nd);
      push_ser = ser; push_ipr = ipr; push_fault = flt;
   endtask

   task automatic nxt();
      @(negedge clk);
   endtask

   initial begin
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #2;
      // R1 reset state
      chk("R1 buf_count", int'(buf_count), 0);
      chk("R1 pop_valid", int'(pop_valid), 0);
      chk("R1 idle", int'(idle), 1);
      chk("R1 free_regs", int'(free_regs), NPH);
      chk("R1 rename_blk", int'(rename_blk), 0);
      chk("R1 push_ready", int'(push_ready), 1);
      nxt();

      // R2 R11 R12: table walk, pushes in cycles 0..3, release from cycle 4
      for (int c = 0; c < 8; c++) begin
         clr();
         if (c < 4) push(int'(VEC[c].seq), int'(VEC[c].nd), 0, 0, VEC[c].flt);
         #2;
         if (c == 0) chk("R12 idle before push", int'(idle), 1);
         if (c == 1) chk("R12 idle after push", int'(idle), 0);
         chk("R2 release timing", int'(pop_valid), (c >= LAT + 1) ? 1 : 0);
         chk("R11 count grows", int'(buf_count), (c < 4) ? c : 4);
         if (c < 4) chk("R5 ready below cap", int'(push_ready), 1);
         nxt();
      end
      clr(); #2;
      chk("R4 free after pushes", int'(free_regs), NPH - 4);
      for (int c = 0; c < 4; c++) begin
         clr(); pop_en = 1; #2;
         chk("R2 pop_valid", int'(pop_valid), 1);
         chk("R2 order seq", int'(pop_seq), int'(VEC[c].seq));
         chk("R2 ndst", int'(pop_ndst), int'(VEC[c].nd));
         chk("R2 fault", int'(pop_fault), int'(VEC[c].flt));
         nxt();
      end
      clr(); pop_en = 1; #2;
      chk("R10 empty pop_valid", int'(pop_valid), 0);
      chk("R4 pops keep free", int'(free_regs), NPH - 4);
      nxt();
      clr(); #2;
      chk("R10 empty pop no effect", int'(buf_count), 0);
      nxt();

      // R4 rename block: free 6, push ndst 7
      clr(); push(5, 7, 0, 0, 0); nxt();
      clr(); push(6, 1, 0, 0, 0); #2;
      chk("R4 free negative", int'(free_regs), -1);
      chk("R4 rename_blk", int'(rename_blk), 1);
      chk("R4 push_ready low", int'(push_ready), 0);
      nxt();
      clr(); squash = 1; squash_seq = 8'd4; #2;
      chk("R4 blocked push ignored", int'(buf_count), 1);
      chk("R7 squash ready low", int'(push_ready), 0);
      nxt();
      clr(); #2;
      chk("R6 free returned", int'(free_regs), NPH - 4);
      chk("R6 count after squash", int'(buf_count), 0);
      chk("R4 rename_blk cleared", int'(rename_blk), 0);
      nxt();
      for (int c = 0; c < LAT + 2; c++) begin
         clr(); #2;
         chk("R6 squashed never released", int'(pop_valid), 0);
         nxt();
      end

      // R5 cap, then R6/R7 squash across both queues
      for (int c = 0; c < 6; c++) begin
         clr(); push(10 + c, 0, 0, 0, 0); #2;
         chk("R5 ready below cap", int'(push_ready), 1);
         nxt();
      end
      clr(); push(16, 0, 0, 0, 0); #2;
      chk("R5 count at cap", int'(buf_count), MAXB);
      chk("R5 ready at cap", int'(push_ready), 0);
      nxt();
      clr(); push(16, 0, 0, 0, 0); pop_en = 1; squash = 1; squash_seq = 8'd12; #2;
      chk("R5 push at cap ignored", int'(buf_count), MAXB);
      chk("R7 squash pop_valid low", int'(pop_valid), 0);
      chk("R7 squash ready low", int'(push_ready), 0);
      nxt();
      clr(); #2;
      chk("R6 survivors counted", int'(buf_count), 3);
      nxt();
      for (int c = 0; c < 3; c++) begin
         clr(); pop_en = 1; #2;
         chk("R6 survivor valid", int'(pop_valid), 1);
         chk("R6 survivor seq", int'(pop_seq), 10 + c);
         nxt();
      end
      for (int c = 0; c < LAT + 2; c++) begin
         clr(); #2;
         chk("R6 staged victims gone", int'(pop_valid), 0);
         chk("R11 count drained", int'(buf_count), 0);
         nxt();
      end

      // R6 frozen history delays a staged survivor by one cycle
      clr(); push(20, 1, 0, 0, 0); nxt();
      clr(); push(21, 2, 0, 0, 0); nxt();
      clr(); squash = 1; squash_seq = 8'd20; nxt();
      clr(); #2;
      chk("R6 free after partial squash", int'(free_regs), NPH - 5);
      chk("R6 count after partial squash", int'(buf_count), 1);
      nxt();
      clr(); #2;
      chk("R6 survivor not yet out", int'(pop_valid), 0);
      nxt();
      clr(); pop_en = 1; #2;
      chk("R6 survivor one cycle late", int'(pop_valid), 1);
      chk("R6 survivor seq", int'(pop_seq), 20);
      nxt();

      // R8 serialize-before head waits for an empty reorder buffer
      clr(); push(30, 0, 1, 0, 0); rob_empty = 0; nxt();
      for (int c = 1; c < 6; c++) begin
         clr(); rob_empty = 0; pop_en = 1; #2;
         chk("R8 serial held", int'(pop_valid), 0);
         nxt();
      end
      clr(); rob_empty = 1; pop_en = 1; #2;
      chk("R8 serial held count", int'(buf_count), 1);
      chk("R8 serial released", int'(pop_valid), 1);
      chk("R8 serial seq", int'(pop_seq), 30);
      nxt();
      clr(); push(31, 0, 0, 1, 0); nxt();
      for (int c = 1; c < 4; c++) begin clr(); rob_empty = 0; nxt(); end
      clr(); rob_empty = 0; pop_en = 1; #2;
      chk("R8 privileged held", int'(pop_valid), 0);
      nxt();
      clr(); pop_en = 1; #2;
      chk("R8 privileged released", int'(pop_valid), 1);
      chk("R8 privileged flag", int'(pop_ipr), 1);
      nxt();
      clr(); push(32, 0, 0, 0, 0); nxt();
      for (int c = 1; c < 4; c++) begin clr(); rob_empty = 0; nxt(); end
      clr(); rob_empty = 0; pop_en = 1; #2;
      chk("R8 plain not held", int'(pop_valid), 1);
      nxt();

      // R9 flush with tokens split across both queues
      for (int c = 0; c < 3; c++) begin clr(); push(40 + c, 1, 0, 0, 0); nxt(); end
      clr(); #2;
      chk("R4 free before flush", int'(free_regs), NPH - 8);
      nxt();
      clr(); flush = 1; #2;
      chk("R9 flush pop_valid low", int'(pop_valid), 0);
      nxt();
      clr(); #2;
      chk("R9 count cleared", int'(buf_count), 0);
      chk("R9 idle set", int'(idle), 1);
      chk("R9 free returned", int'(free_regs), NPH - 5);
      nxt();
      for (int c = 0; c < LAT + 2; c++) begin
         clr(); #2;
         chk("R9 no stale release", int'(pop_valid), 0);
         nxt();
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual running expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule